// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

This block is a combinational shifter for a 32-bit datapath. It sits beside the ALU. It takes a data word, a 5-bit distance and a 2-bit mode, and returns the shifted word in the same evaluation. There is no iteration and no state.

One network of multiplexers handles all four operations. Five cascaded stages move the word by 1, 2, 4, 8 and 16 positions. Each stage is enabled by the matching bit of the distance. The mode decides three things:

- the direction of movement;
- whether vacated positions take zeros or the sign bit;
- whether bits leaving the top come back in at the bottom.

A left arithmetic mode is not provided, because for two's-complement values it is the same as the zero-fill left shift.

Top module: `barrel_shifter`

## Requirements
- R1: Any distance from 0 to 31 is applied to the 32-bit word, and the result follows the inputs combinationally, with no clock and no internal state.
- R2: Mode 2'b00 (zero-fill left) gives the word moved toward the MSB by the distance, with the vacated low positions set to 0.
- R3: Mode 2'b01 (zero-fill right) gives the word moved toward the LSB by the distance, with the vacated high positions set to 0.
- R4: Mode 2'b10 (sign-fill right) moves the word toward the LSB and fills the vacated high positions with copies of the input bit 31. A distance of 31 therefore gives all-ones or all-zeros.
- R5: Mode 2'b11 (rotate left) sets result bit i to input bit (i - distance) mod 32. Bits leaving the top re-enter at the bottom and no bit is lost.
- R6: A distance of zero passes the input word through unchanged in every mode.
- R7: For an input whose bit 31 is 0, sign-fill right and zero-fill right give identical results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Word to be shifted |
| amount_i | input | 5 | Shift distance, 0 to 31 |
| mode_i | input | 2 | 00 zero-fill left, 01 zero-fill right, 10 sign-fill right, 11 rotate left |
| result_o | output | 32 | Shifted word |

## Verification
The immediate assertions check the following whenever the inputs change:

- every stage whose enable bit is clear passes its word through unchanged;
- a zero distance returns the input word;
- the vacated positions of the left and right zero-fill modes are zero;
- the sign-fill mode keeps bit 31;
- rotation preserves the population count.

Only the bench's sweep can show the following, by comparing the whole word against arithmetically computed results for every mode, every distance and a range of data patterns:

- that each bit lands in the right position;
- that sign-fill and zero-fill agree on non-negative inputs;
- that rotation re-enters bits in order.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned AMT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    MODE_SLL = 2'b00,
    MODE_SRL = 2'b01,
    MODE_SRA = 2'b10,
    MODE_ROL = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/barrel_mode_decode.sv
module barrel_mode_decode
  import barrel_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       sign_i,
  output logic       left_o,
  output logic       rotate_o,
  output logic       fill_o
);
  shift_mode_e mode;
  assign mode = shift_mode_e'(mode_i);

  always_comb begin
    left_o   = (mode == MODE_SLL) || (mode == MODE_ROL);
    rotate_o = (mode == MODE_ROL);
    fill_o   = (mode == MODE_SRA) && sign_i;
  end
endmodule

// File: rtl/barrel_stage.sv
module barrel_stage #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DIST  = 1
) (
  input  logic             en_i,
  input  logic             left_i,
  input  logic             rotate_i,
  input  logic             fill_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o
);
  logic [DIST-1:0] low_fill;
  assign low_fill = rotate_i ? data_i[WIDTH-1 -: DIST] : {DIST{1'b0}};

  always_comb begin
    if (!en_i)        data_o = data_i;
    else if (left_i)  data_o = {data_i[WIDTH-DIST-1:0], low_fill};
    else              data_o = {{DIST{fill_i}}, data_i[WIDTH-1:DIST]};
  end

  always_comb begin
    if (!en_i) AST_STAGE_BYPASS: assert (data_o == data_i); // R6
  end
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import barrel_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  localparam int unsigned SW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SW-1:0]    amount_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] result_o
);
  logic left, rotate, fill;
  logic [WIDTH-1:0] stage_q [SW+1];

  barrel_mode_decode u_dec (
    .mode_i   (mode_i),
    .sign_i   (data_i[WIDTH-1]),
    .left_o   (left),
    .rotate_o (rotate),
    .fill_o   (fill)
  );

  assign stage_q[0] = data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    barrel_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
      .en_i     (amount_i[k]),
      .left_i   (left),
      .rotate_i (rotate),
      .fill_i   (fill),
      .data_i   (stage_q[k]),
      .data_o   (stage_q[k+1])
    );
  end

  assign result_o = stage_q[SW];

  logic [WIDTH-1:0] low_mask, high_mask;
  assign low_mask  = ~({WIDTH{1'b1}} << amount_i);
  assign high_mask = ~({WIDTH{1'b1}} >> amount_i);

  always_comb begin
    if (amount_i == '0) AST_ZERO_PASS: assert (result_o == data_i); // R6
    if (mode_i == 2'b00) AST_SLL_LOW_ZERO: assert ((result_o & low_mask) == '0); // R2
    if (mode_i == 2'b01) AST_SRL_HIGH_ZERO: assert ((result_o & high_mask) == '0); // R3
    if (mode_i == 2'b10) AST_SRA_SIGN_KEPT: assert (result_o[WIDTH-1] == data_i[WIDTH-1]); // R4
    if (mode_i == 2'b11) AST_ROL_POPCOUNT: assert ($countones(result_o) == $countones(data_i)); // R5
  end
endmodule

// File: tb/tb_barrel_shifter.sv
module tb_barrel_shifter;
  logic        clk = 1'b0;
  logic [31:0] data;
  logic [4:0]  amount;
  logic [1:0]  mode;
  logic [31:0] result;
  int          checks = 0;
  int          fails  = 0;
  int          cycles = 0;
  bit          done   = 1'b0;

  always #10 clk = ~clk;

  barrel_shifter dut (
    .data_i   (data),
    .amount_i (amount),
    .mode_i   (mode),
    .result_o (result)
  );

  function automatic logic [31:0] model(input logic [31:0] d, input int a, input int m);
    case (m)
      0:       return d << a;
      1:       return d >> a;
      2:       return 32'($signed(d) >>> a);
      default: return (a == 0) ? d : ((d << a) | (d >> (32 - a)));
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d amt=%0d data=%h actual=%h expected=%h",
               req, mode, amount, data, result, exp);
    end
  endtask

  task automatic apply(input logic [31:0] d, input int a, input int m);
    @(posedge clk);
    data = d; amount = 5'(a); mode = 2'(m);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] pats [8];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0001; pats[3] = 32'h7FFF_FFFE;
    pats[4] = 32'hDEAD_BEEF; pats[5] = 32'h1234_5678;
    pats[6] = $urandom();    pats[7] = $urandom() | 32'h8000_0000;

    // R1: all-zero input gives all-zero output
    apply(32'h0, 0, 0);
    check("R1 idle", 32'h0);

    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 8; p++) begin
          string tag;
          apply(pats[p], a, m);
          case (m)
            0: tag = "R2 sll";
            1: tag = "R3 srl";
            2: tag = "R4 sra";
            default: tag = "R5 rol";
          endcase
          if (a == 0) tag = "R6 zero";
          check(tag, model(pats[p], a, m));
        end

    // R4: distance 31 broadcasts the sign
    apply(32'h8000_0000, 31, 2); check("R4 sra31 neg", 32'hFFFF_FFFF);
    apply(32'h7FFF_FFFF, 31, 2); check("R4 sra31 pos", 32'h0);
    // R5: single top bit wraps to bit 0
    apply(32'h8000_0000, 1, 3);  check("R5 rol wrap", 32'h0000_0001);
    apply(32'h0000_000F, 30, 3); check("R5 rol split", 32'hC000_0003);
    // R7: positive input, sra equals srl
    for (int a = 0; a < 32; a++) begin
      logic [31:0] d;
      d = $urandom() & 32'h7FFF_FFFF;
      apply(d, a, 2);
      check("R7 sra=srl", d >> a);
    end
    // R1: result tracks inputs within the same cycle, no clock involved
    data = 32'h0000_00F0; amount = 5'd4; mode = 2'd1; #1;
    check("R1 comb", 32'h0000_000F);

    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done || cycles > 20000) begin
      if (!done) begin
        checks++; fails++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule